// File: doc/BRIEF.md
# Block Register-List Transfer Sequencer

This block moves a list of general registers between the register file and a 64-bit data memory port, in either direction. A single-cycle start strobe presents a 16-bit register mask, a base byte address and a direction (load or store). The block then walks the mask from the lowest register number upward. Each memory beat carries up to two 32-bit words. The selected registers occupy consecutive word addresses starting at the base. On every beat the block drives the register-file read or write ports that belong to that beat. Memory is taken to answer in the same cycle.

A per-register pending vector is loaded with the mask on start. Each bit drops as soon as its register has been moved. Issue logic can therefore release an instruction that depends on one listed register without waiting for the whole list. The main pipeline is held for the first transfer cycle only. Once the base is doubleword aligned, registers travel in pairs. An odd word base spends its first beat on the upper half of a doubleword so that every later beat is aligned.

Top module: `blk_xfer_seq`

## Requirements
- R1: Registers are moved in ascending register number. The k-th listed register (k from 0) uses byte address base+4k, and base_addr bits [1:0] are ignored. mem_addr is the doubleword address with bits [2:0] zero. mem_lane[0] selects the word at mem_addr, mem_lane[1] the word at mem_addr+4, and mem_lane is never zero on a beat.
- R2: With base_addr[2]=0, every beat except possibly the last carries two registers. A list of n registers takes ceil(n/2) beats, so 2k and 2k-1 registers cost the same, and three or four registers occupy exactly two consecutive beats.
- R3: With base_addr[2]=1, the first beat carries only the lowest register, in lane 1. Later beats pair registers on aligned doublewords. A list of n registers takes floor(n/2)+1 beats, one more than aligned whenever n is even.
- R4: On an accepted start, pending takes the mask. A pending bit is cleared in the cycle after the beat that moves its register, and is never set at any other time.
- R5: alu_hold is high only in the first cycle after a start with a non-empty mask.
- R6: busy is high from the cycle after start through the last beat. done is a one-cycle pulse in the cycle after the last beat, and pending is all zero while done is high.
- R7: A start with an all-zero mask raises done in the next cycle, with no memory beat and busy staying low.
- R8: On a store, mem_we is 1 and rf_wr_en is 0. Each active lane carries the register-file read data of the register it holds, with read port 0 holding the first register of the beat and port 1 the second.
- R9: On a load, mem_we is 0. rf_wr_en bit 0 is set on every beat, and bit 1 is set on paired beats. Write port 0 receives the first register of the beat with the word of its lane, and port 1 the second register with the upper word.
- R10: A start asserted while busy is ignored: the running transfer continues unchanged and no further transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, accepted only while idle |
| is_load | input | 1 | 1 = memory to registers, 0 = registers to memory |
| reg_mask | input | 16 | Register list, bit i = register i |
| base_addr | input | 32 | Base byte address |
| busy | output | 1 | Transfer in progress |
| alu_hold | output | 1 | Main pipeline interlock, first cycle only |
| done | output | 1 | Completion pulse |
| pending | output | 16 | Registers not yet transferred |
| mem_req | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | 32 | Doubleword-aligned beat address |
| mem_lane | output | 2 | Active word lanes of the beat |
| mem_wdata | output | 64 | Store data, lane 1 in the upper half |
| mem_rdata | input | 64 | Load data, same-cycle response |
| rf_rd_idx0 | output | 4 | Register-file read index, first register |
| rf_rd_idx1 | output | 4 | Register-file read index, second register |
| rf_rd_data0 | input | 32 | Read data for rf_rd_idx0 |
| rf_rd_data1 | input | 32 | Read data for rf_rd_idx1 |
| rf_wr_en | output | 2 | Register-file write enables per port |
| rf_wr_idx0 | output | 4 | Write index, first register |
| rf_wr_idx1 | output | 4 | Write index, second register |
| rf_wr_data0 | output | 32 | Write data, port 0 |
| rf_wr_data1 | output | 32 | Write data, port 1 |

## Verification
Every cycle, the assertions check that the interlock never lasts beyond one cycle, that a beat always has an active lane, and that a pair is always taken in ascending order. They also check that pending bits only ever fall between starts, that completion coincides with an empty pending vector, and that a start seen while busy leaves the latched direction alone. Only the bench scenarios can show the things that depend on the whole list: the exact address and lane of every beat, the total beat count for aligned and odd bases across sparse, single, full and empty masks, and the data routed through each port in both directions. The same applies to the cycle in which each pending bit and done change, and to a start during a transfer leaving no trace.

// File: rtl/blk_xfer_pkg.sv
package blk_xfer_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } xfer_state_e;
endpackage

// File: rtl/blk_lowest.sv
module blk_lowest #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  onehot
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
  end

  assign found  = |vec;
  assign onehot = found ? (N'(1) << idx) : '0;
endmodule

// File: rtl/blk_beat_plan.sv
module blk_beat_plan #(
  parameter int NREG = 16,
  parameter int IW   = $clog2(NREG)
) (
  input  logic [NREG-1:0] remain,
  input  logic            odd_word,
  output logic [IW-1:0]   idx_a,
  output logic [IW-1:0]   idx_b,
  output logic            pair,
  output logic [1:0]      lane,
  output logic [NREG-1:0] clr
);
  logic            fnd_a, fnd_b;
  logic [NREG-1:0] oh_a, oh_b;
  logic [NREG-1:0] rest;

  blk_lowest #(.N(NREG), .IW(IW)) u_first (
    .vec(remain), .found(fnd_a), .idx(idx_a), .onehot(oh_a)
  );

  assign rest = remain & ~oh_a;

  blk_lowest #(.N(NREG), .IW(IW)) u_second (
    .vec(rest), .found(fnd_b), .idx(idx_b), .onehot(oh_b)
  );

  // an odd word address forces a single word into the upper lane
  assign pair = fnd_a & fnd_b & ~odd_word;
  assign clr  = oh_a | (pair ? oh_b : '0);

  always_comb begin
    if (!fnd_a)        lane = 2'b00;
    else if (odd_word) lane = 2'b10;
    else if (pair)     lane = 2'b11;
    else               lane = 2'b01;
  end

  // R1: a pair is always two distinct registers in ascending order
  always_comb begin
    if (pair) p_pair_order_r1: assert (idx_b > idx_a);
  end
endmodule

// File: rtl/blk_pend_track.sv
module blk_pend_track #(
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [NREG-1:0] load_mask,
  input  logic            clr_en,
  input  logic [NREG-1:0] clr_mask,
  output logic [NREG-1:0] pending
);
  logic [NREG-1:0] pend_q, pend_n;
  logic            pend_en;

  assign pend_en = load_en | clr_en;

  always_comb begin
    pend_n = pend_q;
    if (load_en)     pend_n = load_mask;
    else if (clr_en) pend_n = pend_q & ~clr_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= '0;
    else if (pend_en) pend_q <= pend_n;
  end

  assign pending = pend_q;

  // R4: between starts no bit may rise
  p_no_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> ((pend_q & ~$past(pend_q)) == '0));
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq #(
  parameter int NREG = 16,
  parameter int AW   = 32,
  parameter int WW   = 32,
  parameter int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            is_load,
  input  logic [NREG-1:0] reg_mask,
  input  logic [AW-1:0]   base_addr,
  output logic            busy,
  output logic            alu_hold,
  output logic            done,
  output logic [NREG-1:0] pending,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [1:0]      mem_lane,
  output logic [2*WW-1:0] mem_wdata,
  input  logic [2*WW-1:0] mem_rdata,
  output logic [IW-1:0]   rf_rd_idx0,
  output logic [IW-1:0]   rf_rd_idx1,
  input  logic [WW-1:0]   rf_rd_data0,
  input  logic [WW-1:0]   rf_rd_data1,
  output logic [1:0]      rf_wr_en,
  output logic [IW-1:0]   rf_wr_idx0,
  output logic [IW-1:0]   rf_wr_idx1,
  output logic [WW-1:0]   rf_wr_data0,
  output logic [WW-1:0]   rf_wr_data1
);
  import blk_xfer_pkg::*;

  localparam int WBYTES = WW / 8;

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_s2;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end
  logic rst_i;
  assign rst_i = rst_s2;

  xfer_state_e     st_q, st_n;
  logic            first_q, first_n;
  logic            done_q, done_n;
  logic            load_q, load_n;
  logic [AW-1:0]   addr_q, addr_n;
  logic [NREG-1:0] rem_q, rem_n;
  logic            ctx_en, run;

  logic [IW-1:0]   idx_a, idx_b;
  logic            pair;
  logic [1:0]      lane;
  logic [NREG-1:0] clr;
  logic            accept;
  logic            unused_lsb;

  assign unused_lsb = ^base_addr[1:0];
  assign run    = (st_q == ST_RUN);
  assign accept = (st_q == ST_IDLE) & start;

  blk_beat_plan #(.NREG(NREG), .IW(IW)) u_plan (
    .remain(rem_q), .odd_word(addr_q[2]),
    .idx_a(idx_a), .idx_b(idx_b), .pair(pair), .lane(lane), .clr(clr)
  );

  blk_pend_track #(.NREG(NREG)) u_pend (
    .clk(clk), .rst_n(rst_i),
    .load_en(accept), .load_mask(reg_mask),
    .clr_en(run), .clr_mask(clr),
    .pending(pending)
  );

  // next-state
  always_comb begin
    st_n    = st_q;
    first_n = 1'b0;
    done_n  = 1'b0;
    load_n  = load_q;
    addr_n  = addr_q;
    rem_n   = rem_q;
    ctx_en  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          ctx_en = 1'b1;
          load_n = is_load;
          addr_n = {base_addr[AW-1:2], 2'b00};
          rem_n  = reg_mask;
          if (reg_mask == '0) begin
            done_n = 1'b1;
          end else begin
            st_n    = ST_RUN;
            first_n = 1'b1;
          end
        end
      end
      ST_RUN: begin
        ctx_en = 1'b1;
        rem_n  = rem_q & ~clr;
        addr_n = addr_q + AW'(pair ? 2 * WBYTES : WBYTES);
        if (rem_n == '0) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q    <= ST_IDLE;
      first_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st_q    <= st_n;
      first_q <= first_n;
      done_q  <= done_n;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      load_q <= 1'b0;
      addr_q <= '0;
      rem_q  <= '0;
    end else if (ctx_en) begin
      load_q <= load_n;
      addr_q <= addr_n;
      rem_q  <= rem_n;
    end
  end

  // outputs
  assign busy     = run;
  assign alu_hold = run & first_q;
  assign done     = done_q;
  assign mem_req  = run;
  assign mem_we   = run & ~load_q;
  assign mem_addr = {addr_q[AW-1:3], 3'b000};
  assign mem_lane = run ? lane : 2'b00;

  assign rf_rd_idx0 = idx_a;
  assign rf_rd_idx1 = idx_b;
  assign mem_wdata  = {(addr_q[2] ? rf_rd_data0 : rf_rd_data1), rf_rd_data0};

  assign rf_wr_en    = (run & load_q) ? {pair, 1'b1} : 2'b00;
  assign rf_wr_idx0  = idx_a;
  assign rf_wr_idx1  = idx_b;
  assign rf_wr_data0 = addr_q[2] ? mem_rdata[2*WW-1:WW] : mem_rdata[WW-1:0];
  assign rf_wr_data1 = mem_rdata[2*WW-1:WW];

  // R5: interlock lasts one cycle
  p_hold_once_r5: assert property (@(posedge clk) disable iff (!rst_i)
    alu_hold |=> !alu_hold);

  // R1: every beat has at least one active lane
  p_lane_live_r1: assert property (@(posedge clk) disable iff (!rst_i)
    mem_req |-> (mem_lane != 2'b00));

  // R6: completion only with nothing left pending and not busy
  p_done_empty_r6: assert property (@(posedge clk) disable iff (!rst_i)
    done |-> (pending == '0) && !busy);

  // R10: a start during a transfer does not disturb its direction
  p_busy_start_r10: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && start) |=> $stable(load_q));
endmodule

// File: tb/sim_blk_xfer_seq.sv
`timescale 1ns/1ps
module sim_blk_xfer_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        is_load = 1'b0;
  logic [15:0] reg_mask = '0;
  logic [31:0] base_addr = '0;
  logic        busy, alu_hold, done, mem_req, mem_we;
  logic [15:0] pending;
  logic [31:0] mem_addr;
  logic [1:0]  mem_lane, rf_wr_en;
  logic [63:0] mem_wdata, mem_rdata;
  logic [3:0]  rf_rd_idx0, rf_rd_idx1, rf_wr_idx0, rf_wr_idx1;
  logic [31:0] rf_rd_data0, rf_rd_data1, rf_wr_data0, rf_wr_data1;

  int checks = 0;
  int fails  = 0;
  bit ended  = 0;

  always #2.5 clk = ~clk;

  function automatic logic [31:0] memword(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction
  function automatic logic [31:0] rfval(input logic [3:0] i);
    return 32'hC0DE_0000 | 32'(i);
  endfunction

  assign mem_rdata   = {memword(mem_addr + 32'd4), memword(mem_addr)};
  assign rf_rd_data0 = rfval(rf_rd_idx0);
  assign rf_rd_data1 = rfval(rf_rd_idx1);

  blk_xfer_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .is_load(is_load),
    .reg_mask(reg_mask), .base_addr(base_addr),
    .busy(busy), .alu_hold(alu_hold), .done(done), .pending(pending),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_lane(mem_lane), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rf_rd_idx0(rf_rd_idx0), .rf_rd_idx1(rf_rd_idx1),
    .rf_rd_data0(rf_rd_data0), .rf_rd_data1(rf_rd_data1),
    .rf_wr_en(rf_wr_en), .rf_wr_idx0(rf_wr_idx0), .rf_wr_idx1(rf_wr_idx1),
    .rf_wr_data0(rf_wr_data0), .rf_wr_data1(rf_wr_data1)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] a;
    logic [1:0]  lane;
    logic [3:0]  r0, r1;
    logic        pair;
    logic        ld;
  } beat_t;

  beat_t       expq[$];
  logic [15:0] exp_pend = '0;

  // monitor: pops one expected beat per observed beat
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (expq.size() == 0) begin
        chk(0, "R10", "unexpected beat", {32'd0, mem_addr}, 64'd0);
      end else begin
        beat_t e;
        e = expq.pop_front();
        chk(mem_addr == e.a, "R1", "beat address", {32'd0, mem_addr}, {32'd0, e.a});
        chk(mem_lane == e.lane, e.a[2] ? "R3" : "R2", "beat lanes",
            {62'd0, mem_lane}, {62'd0, e.lane});
        chk(pending == exp_pend, "R4", "pending before beat",
            {48'd0, pending}, {48'd0, exp_pend});
        if (!e.ld) begin
          chk(mem_we && rf_wr_en == 2'b00, "R8", "store control",
              {62'd0, mem_we, |rf_wr_en}, 64'd2);
          if (e.lane[0])
            chk(mem_wdata[31:0] == rfval(e.r0), "R8", "store low word",
                {32'd0, mem_wdata[31:0]}, {32'd0, rfval(e.r0)});
          if (e.lane[1])
            chk(mem_wdata[63:32] == rfval(e.pair ? e.r1 : e.r0), "R8", "store high word",
                {32'd0, mem_wdata[63:32]}, {32'd0, rfval(e.pair ? e.r1 : e.r0)});
        end else begin
          logic [31:0] w0;
          w0 = memword(e.a + (e.lane == 2'b10 ? 32'd4 : 32'd0));
          chk(!mem_we && rf_wr_en == {e.pair, 1'b1}, "R9", "load write enables",
              {62'd0, rf_wr_en}, {62'd0, e.pair, 1'b1});
          chk(rf_wr_idx0 == e.r0 && rf_wr_data0 == w0, "R9", "load port 0",
              {28'd0, rf_wr_idx0, rf_wr_data0}, {28'd0, e.r0, w0});
          if (e.pair)
            chk(rf_wr_idx1 == e.r1 && rf_wr_data1 == memword(e.a + 32'd4), "R9",
                "load port 1", {28'd0, rf_wr_idx1, rf_wr_data1},
                {28'd0, e.r1, memword(e.a + 32'd4)});
        end
        exp_pend = exp_pend & ~(16'(1) << e.r0);
        if (e.pair) exp_pend = exp_pend & ~(16'(1) << e.r1);
      end
    end
  end

  task automatic run_op(input logic [15:0] mask, input logic [31:0] base,
                        input bit ld, input bit poke);
    logic [31:0] a;
    int          regs[$];
    int          nb, cyc;
    bit          late_hold;
    a = {base[31:2], 2'b00};
    for (int i = 0; i < 16; i++) if (mask[i]) regs.push_back(i);
    nb = 0;
    while (regs.size() > 0) begin
      beat_t b;
      b.a = {a[31:3], 3'b000};
      b.ld = ld;
      b.r0 = 4'(regs.pop_front());
      b.r1 = 4'd0;
      if (a[2]) begin
        b.lane = 2'b10; b.pair = 0; a = a + 32'd4;
      end else if (regs.size() > 0) begin
        b.r1 = 4'(regs.pop_front());
        b.lane = 2'b11; b.pair = 1; a = a + 32'd8;
      end else begin
        b.lane = 2'b01; b.pair = 0; a = a + 32'd4;
      end
      expq.push_back(b);
      nb++;
    end
    @(negedge clk);
    reg_mask = mask; base_addr = base; is_load = ld; start = 1'b1;
    exp_pend = mask;
    @(negedge clk);
    start = 1'b0;
    if (mask == '0) begin
      chk(done && !busy && !mem_req, "R7", "empty mask completion",
          {61'd0, done, busy, mem_req}, 64'd4);
      @(negedge clk);
      chk(!done && !busy, "R7", "empty mask quiet after", {62'd0, done, busy}, 64'd0);
      return;
    end
    chk(busy && alu_hold, "R5", "hold in first cycle", {62'd0, busy, alu_hold}, 64'd3);
    chk(pending == mask, "R4", "pending loaded", {48'd0, pending}, {48'd0, mask});
    cyc = 1;
    late_hold = 0;
    while (!done && cyc < 100) begin
      if (cyc >= 2 && alu_hold) late_hold = 1;
      if (poke && cyc == 2) begin
        reg_mask = 16'h8000; is_load = ~ld; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(!late_hold, "R5", "hold beyond first cycle", {63'd0, late_hold}, 64'd0);
    chk(cyc == nb + 1, "R6", "done cycle", 64'(cyc), 64'(nb + 1));
    chk(!busy && pending == '0, "R6", "idle at done", {47'd0, busy, pending}, 64'd0);
    chk(expq.size() == 0, ld ? "R9" : "R8", "beats left over", 64'(expq.size()), 64'd0);
    @(negedge clk);
    chk(!done && !busy, "R6", "done single pulse", {62'd0, done, busy}, 64'd0);
    @(negedge clk);
    chk(!busy && !mem_req, "R10", "no follow-on transfer", {62'd0, busy, mem_req}, 64'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!ended) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !mem_req && pending == '0 && rf_wr_en == 2'b00, "R6",
        "reset state", {45'd0, busy, done, mem_req, pending}, 64'd0);
    run_op(16'h000F, 32'h0000_0100, 1, 0);  // R2: four regs, two beats
    run_op(16'h0007, 32'h0000_0200, 0, 0);  // R2: three regs, two beats
    run_op(16'h000F, 32'h0000_0104, 1, 0);  // R3: even count, extra beat
    run_op(16'h0007, 32'h0000_0204, 0, 0);  // R3: odd count
    run_op(16'h8421, 32'h0000_0302, 0, 0);  // R1: sparse, low bits ignored
    run_op(16'h8000, 32'h0000_040C, 1, 0);  // R3: single register
    run_op(16'h0001, 32'h0000_0500, 1, 0);  // R2: single aligned
    run_op(16'hFFFF, 32'h0000_1000, 1, 0);  // R2: full list
    run_op(16'hFFFF, 32'h0000_2004, 0, 0);  // R3: full list odd base
    run_op(16'h0000, 32'h0000_3000, 1, 0);  // R7: empty mask
    run_op(16'h00FF, 32'h0000_3100, 0, 1);  // R10: start while busy
    run_op(16'hA5A5, 32'h0000_3204, 1, 0);  // R4: sparse load odd base
    ended = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule